// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block turns level changes on general-purpose port pins into interrupt requests and event strobes. It serves sixteen lines. Line n can only listen to pin n of one of the attached ports, and software picks which port through a small select field per line. The chosen pin is brought into the clock domain by a two-flop synchronizer. Its rising and falling transitions are then qualified by per-line trigger enables.

A qualified edge always records a pending flag, whatever the masks say. The interrupt request for a line is the pending flag gated by that line's interrupt mask, and it stays high until software writes a 1 to the pending bit. Events are separate. A qualified edge on a line whose event mask is set gives a pulse of exactly one clock, and no state is kept for it. All configuration and the pending flags are reached through a plain synchronous register bus.

Top module: `edge_irq_router`

## Requirements
- R1: After reset, every select field, trigger enable, interrupt mask, event mask and pending bit reads 0, and both `irq_req` and `evt_pulse` are all zero.
- R2: Line n samples `port_pins[p*16+n]`, where p is the 4-bit field at bits [4*(n%4)+3 : 4*(n%4)] of the select word at address n/4 (addresses 0 to 3). Toggling pin n of any other port leaves line n untouched.
- R3: A select value of NUM_PORTS or more makes the line read a constant low, so no edge is ever detected on it.
- R4: With bit n of the rising-enable register (address 4) set, a 0-to-1 transition of line n sets pending bit n.
- R5: With bit n of the falling-enable register (address 5) set, a 1-to-0 transition sets pending bit n. With both enables set, both edges count. With neither set, no edge counts.
- R6: A pin change applied between clock edges becomes visible in `pending`, `irq_req` and `evt_pulse` on the third rising clock edge after it, and not earlier.
- R7: `irq_req[n]` equals pending[n] AND bit n of the interrupt-mask register (address 6). Pending sets whatever the mask holds, and setting the mask later raises the request.
- R8: With bit n of the event-mask register (address 7) set, an enabled edge drives `evt_pulse[n]` high for exactly one clock, in the same cycle that pending sets. The next cycle it is low again, even while pending stays set.
- R9: The pending register (address 8) reads back the pending flags. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: If an enabled edge and a write-1-to-clear reach the same line in the same clock, the pending bit stays set.
- R11: `bus_rdata` is registered. It shows the addressed register in the cycle after `bus_rd_en`, written registers read back as written, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | NUM_PORTS*16 | Asynchronous pin levels; port p occupies bits [p*16+15:p*16] |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd_en` |
| irq_req | output | 16 | Per-line interrupt request levels |
| evt_pulse | output | 16 | Per-line one-clock event strobes |

## Verification
The main sweep covers every line, every existing port and all four trigger settings. On each combination it raises and then lowers the routed pin. The sweep shows whether each edge direction is gated by its own enable, and whether the result lands on the right line in the right cycle, one cycle earlier being a failure. Before each edge the same-index pin of a neighbouring port is toggled, which separates correct routing from a mux that picks the wrong column. Directed patterns follow: an out-of-range select with every port toggling, an edge with the interrupt mask off that is unmasked afterwards, a write of zeros to the pending register, and a clear that coincides with a fresh edge. These show that pending is recorded apart from the mask and that a new edge wins over a clear.

// File: rtl/eir_pkg.sv
package eir_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_RISE = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_FALL = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_IMSK = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_EMSK = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_PEND = 4'd8;
endpackage

// File: rtl/eir_route.sv
module eir_route #(
  parameter int LINES = 16,
  parameter int PORTS = 6,
  parameter int SEL_W = 4
) (
  input  logic [PORTS*LINES-1:0] port_pins,
  input  logic [LINES*SEL_W-1:0] sel_flat,
  output logic [LINES-1:0]       line_in
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [SEL_W-1:0] sel;
    logic [PORTS-1:0] column;
    logic             pick;

    assign sel = sel_flat[n*SEL_W +: SEL_W];

    for (genvar p = 0; p < PORTS; p++) begin : g_col
      assign column[p] = port_pins[p*LINES+n];
    end

    // A select value past the last port leaves pick low.
    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < PORTS; p++) begin
        if (int'(sel) == p) pick = column[p];
      end
    end

    assign line_in[n] = pick;
  end
endmodule

// File: rtl/eir_edge.sv
module eir_edge #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] rise_en,
  input  logic [LINES-1:0] fall_en,
  output logic [LINES-1:0] hit
);
  logic [LINES-1:0] meta_q;
  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= line_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign hit = (sync_q & ~last_q & rise_en) | (~sync_q & last_q & fall_en);

  // R6
  // One register stands between the synchronizer output and the edge history.
  sync_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (last_q == $past(sync_q)));
endmodule

// File: rtl/eir_regs.sv
module eir_regs
  import eir_pkg::*;
#(
  parameter int LINES = 16,
  parameter int SEL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr_en,
  input  logic                   bus_rd_en,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [LINES-1:0]       bus_wdata,
  output logic [LINES-1:0]       bus_rdata,
  input  logic [LINES-1:0]       hit,
  output logic [LINES*SEL_W-1:0] sel_flat,
  output logic [LINES-1:0]       rise_en,
  output logic [LINES-1:0]       fall_en,
  output logic [LINES-1:0]       irq_req,
  output logic [LINES-1:0]       evt_pulse
);
  localparam int FIELDS_PER_WORD = LINES / SEL_W;
  localparam int SEL_WORDS       = LINES / FIELDS_PER_WORD;

  logic [LINES*SEL_W-1:0] sel_q;
  logic [LINES-1:0] rise_q, fall_q, imask_q, emask_q, pend_q;
  logic [LINES-1:0] irq_q, evt_q, rdata_q;
  logic [LINES-1:0] clr_mask, pend_d, imask_d, rd_mux;

  assign clr_mask = (bus_wr_en && bus_addr == ADR_PEND) ? bus_wdata : '0;
  // A fresh edge is ORed in after the clear, so it wins.
  assign pend_d   = (pend_q & ~clr_mask) | hit;
  assign imask_d  = (bus_wr_en && bus_addr == ADR_IMSK) ? bus_wdata : imask_q;

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (int'(bus_addr) == w) rd_mux = sel_q[w*LINES +: LINES];
    end
    case (bus_addr)
      ADR_RISE: rd_mux = rise_q;
      ADR_FALL: rd_mux = fall_q;
      ADR_IMSK: rd_mux = imask_q;
      ADR_EMSK: rd_mux = emask_q;
      ADR_PEND: rd_mux = pend_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      imask_q <= '0;
      emask_q <= '0;
      pend_q  <= '0;
      irq_q   <= '0;
      evt_q   <= '0;
      rdata_q <= '0;
    end else begin
      for (int w = 0; w < SEL_WORDS; w++) begin
        if (bus_wr_en && int'(bus_addr) == w) sel_q[w*LINES +: LINES] <= bus_wdata;
      end
      if (bus_wr_en && bus_addr == ADR_RISE) rise_q  <= bus_wdata;
      if (bus_wr_en && bus_addr == ADR_FALL) fall_q  <= bus_wdata;
      if (bus_wr_en && bus_addr == ADR_EMSK) emask_q <= bus_wdata;
      imask_q <= imask_d;
      pend_q  <= pend_d;
      irq_q   <= pend_d & imask_d;
      evt_q   <= hit & emask_q;
      if (bus_rd_en) rdata_q <= rd_mux;
    end
  end

  assign sel_flat  = sel_q;
  assign rise_en   = rise_q;
  assign fall_en   = fall_q;
  assign irq_req   = irq_q;
  assign evt_pulse = evt_q;
  assign bus_rdata = rdata_q;

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q & imask_q));

  // R8
  evt_mask_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_q & ~$past(emask_q)) == '0));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((pend_q & $past(clr_mask & ~hit)) == '0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (pend_q == '0 && irq_q == '0 && evt_q == '0));
endmodule

// File: rtl/edge_irq_router.sv
module edge_irq_router
  import eir_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 6,
  parameter int SEL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [NUM_LINES-1:0]       bus_wdata,
  output logic [NUM_LINES-1:0]       bus_rdata,
  output logic [NUM_LINES-1:0]       irq_req,
  output logic [NUM_LINES-1:0]       evt_pulse
);
  logic [NUM_LINES*SEL_W-1:0] sel_flat;
  logic [NUM_LINES-1:0]       line_in, rise_en, fall_en, hit;

  eir_route #(.LINES(NUM_LINES), .PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_route (
    .port_pins (port_pins),
    .sel_flat  (sel_flat),
    .line_in   (line_in)
  );

  eir_edge #(.LINES(NUM_LINES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .line_in (line_in),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hit     (hit)
  );

  eir_regs #(.LINES(NUM_LINES), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hit       (hit),
    .sel_flat  (sel_flat),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .irq_req   (irq_req),
    .evt_pulse (evt_pulse)
  );
endmodule

// File: tb/edge_irq_router_tb.sv
module edge_irq_router_tb;
  localparam int P = 6;
  localparam int L = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [P*L-1:0] pins = '0;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [L-1:0]  bus_wdata = '0;
  logic [L-1:0]  bus_rdata, irq_req, evt_pulse;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_router u_dut (
    .clk(clk), .rst(rst), .port_pins(pins),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [L-1:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [L-1:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  // One sweep point: line n routed to port p with trigger setting cfg.
  task automatic sweep_point(input int n, input int p, input logic [1:0] cfg);
    logic [L-1:0] bit_n, r;
    logic [L-1:0] exp_r, exp_f;
    int q;
    bit_n = L'(1) << n;
    exp_r = cfg[0] ? bit_n : '0;
    exp_f = cfg[1] ? bit_n : '0;
    q = (p + 1) % P;
    wr(4'(n / 4), L'(p) << (4 * (n % 4)));
    wr(4'd4, exp_r);
    wr(4'd5, exp_f);
    wr(4'd6, bit_n);
    wr(4'd7, bit_n);
    wr(4'd8, '1);
    // R2: the same-index pin of another port must not reach line n
    pins[q*L+n] = 1'b1;
    repeat (4) @(negedge clk);
    pins[q*L+n] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 neighbour port isolated", 32'(irq_req), 32'h0);
    // rising edge
    pins[p*L+n] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 no early rise", 32'(evt_pulse | irq_req), 32'h0);
    @(negedge clk);
    chk("R4 rise event", 32'(evt_pulse), 32'(exp_r));
    chk("R7 rise irq", 32'(irq_req), 32'(exp_r));
    @(negedge clk);
    chk("R8 event one cycle", 32'(evt_pulse), 32'h0);
    rd(4'd8, r);
    chk("R9 pending after rise", 32'(r), 32'(exp_r));
    wr(4'd8, bit_n);
    chk("R9 cleared", 32'(irq_req), 32'h0);
    // falling edge
    pins[p*L+n] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 no early fall", 32'(evt_pulse | irq_req), 32'h0);
    @(negedge clk);
    chk("R5 fall event", 32'(evt_pulse), 32'(exp_f));
    chk("R5 fall irq", 32'(irq_req), 32'(exp_f));
    @(negedge clk);
    chk("R8 event low after fall", 32'(evt_pulse), 32'h0);
  endtask

  initial begin
    logic [L-1:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq_req), 32'h0);
    chk("R1 evt after reset", 32'(evt_pulse), 32'h0);
    for (int a = 0; a <= 8; a++) begin
      rd(4'(a), r);
      chk("R1 register reset", 32'(r), 32'h0);
    end

    // R11 readback and unmapped address
    wr(4'd2, 16'h5A3C);
    rd(4'd2, r);
    chk("R11 select readback", 32'(r), 32'h5A3C);
    wr(4'd5, 16'h8421);
    rd(4'd5, r);
    chk("R11 falling readback", 32'(r), 32'h8421);
    rd(4'd15, r);
    chk("R11 unmapped", 32'(r), 32'h0);
    wr(4'd2, '0);
    wr(4'd5, '0);

    // R3 out-of-range select on line 5
    wr(4'd1, 16'h0070);
    wr(4'd4, 16'h0020);
    wr(4'd5, 16'h0020);
    wr(4'd6, 16'h0020);
    for (int p = 0; p < P; p++) pins[p*L+5] = 1'b1;
    repeat (5) @(negedge clk);
    for (int p = 0; p < P; p++) pins[p*L+5] = 1'b0;
    repeat (5) @(negedge clk);
    rd(4'd8, r);
    chk("R3 out-of-range select", 32'(r), 32'h0);
    wr(4'd1, '0);

    // R7 pending regardless of mask: line 3 on port 2
    wr(4'd0, 16'h2000);
    wr(4'd4, 16'h0008);
    wr(4'd5, 16'h0000);
    wr(4'd6, 16'h0000);
    pins[2*L+3] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 masked irq low", 32'(irq_req), 32'h0);
    rd(4'd8, r);
    chk("R7 pending while masked", 32'(r), 32'h0008);
    wr(4'd6, 16'h0008);
    chk("R7 unmask raises irq", 32'(irq_req), 32'h0008);

    // R9 writing zero keeps pending
    wr(4'd8, 16'h0000);
    rd(4'd8, r);
    chk("R9 write zero keeps", 32'(r), 32'h0008);

    // R10 clear coincides with falling edge on line 3
    wr(4'd5, 16'h0008);
    pins[2*L+3] = 1'b0;
    @(negedge clk);
    wr(4'd8, 16'h0008);
    rd(4'd8, r);
    chk("R10 edge beats clear", 32'(r), 32'h0008);
    chk("R10 irq held", 32'(irq_req), 32'h0008);
    wr(4'd0, '0);

    // Sweep every line, port and trigger setting
    for (int n = 0; n < L; n++)
      for (int p = 0; p < P; p++)
        for (int c = 0; c < 4; c++)
          sweep_point(n, p, 2'(c));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule